// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block holds the eight 16-bit working registers of a small processor core: four general registers (A, B, C, D) and four pointer/index registers (stack pointer, base pointer, source index, destination index). Each general register can also be used as two independent 8-bit halves. Its upper half is bits 15:8 and its lower half is bits 7:0.

The file has one write port and two read ports. Every port carries a size bit and a 3-bit register code. With the size bit low the code names a whole word. With the size bit high the code names one byte half of a general register. The pointer and index registers have no byte view.

A byte write changes only the addressed half and leaves the other half of the word as it was. Read data are registered. A read of the register written on the same edge returns the value from before that write.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high on a clock edge, all eight registers are cleared to zero and both read outputs show zero after that edge.
- R2: In word mode (size bit 0), codes 0..7 select A, C, D, B, SP, BP, SI, DI. A word write stores all 16 bits of `wr_data`, and a word read returns all 16 bits.
- R3: In byte mode (size bit 1), codes 0..3 select the low byte (bits 7:0) of A, C, D, B and codes 4..7 select the high byte (bits 15:8) of A, C, D, B. A byte read returns the selected byte in bits 7:0 with bits 15:8 zero.
- R4: A byte write to the low byte (codes 0..3) loads `wr_data[7:0]` into bits 7:0 of the selected register and leaves its bits 15:8 unchanged.
- R5: Read data appear on the edge after the code is presented. A read of the register written on that same edge returns the value from before the write.
- R6: The two read ports are independent. Presenting the same size bit and code on both ports gives the same data on both.
- R7: With `wr_en` low, no register changes, whatever the other write inputs hold.
- R8: A byte write to the high byte (codes 4..7) loads `wr_data[7:0]` into bits 15:8 of the selected register, leaves bits 7:0 unchanged, and ignores `wr_data[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_byte | input | 1 | Write size: 1 byte, 0 word |
| wr_code | input | 3 | Write register code |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd0_byte | input | 1 | Read port 0 size: 1 byte, 0 word |
| rd0_code | input | 3 | Read port 0 register code |
| rd0_data | output | 16 | Read port 0 data, registered |
| rd1_byte | input | 1 | Read port 1 size: 1 byte, 0 word |
| rd1_code | input | 3 | Read port 1 register code |
| rd1_data | output | 16 | Read port 1 data, registered |

## Verification
The bench writes the low half of a register and then the high half with different patterns. It then reads the whole word. A design that merged the halves wrongly would clobber the neighbouring byte. A design that took the high byte from `wr_data[15:8]` would show the wrong pattern.

Byte reads are made with all-ones in the other half, so a missing zero-extension leaks bits into 15:8. Word and byte codes are swept in full, so a wrong code order, such as B placed before C, reads the wrong register. Same-cycle write/read pairs catch a design that forwards the new value. Idle cycles with busy write data catch a write enable that is not honoured.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // Word-mode register codes; byte mode reuses the low codes per split register
  typedef enum logic [2:0] {
    GPR_A  = 3'd0,
    GPR_C  = 3'd1,
    GPR_D  = 3'd2,
    GPR_B  = 3'd3,
    GPR_SP = 3'd4,
    GPR_BP = 3'd5,
    GPR_SI = 3'd6,
    GPR_DI = 3'd7
  } gpr_code_e;
endpackage

// File: rtl/gpr_decode.sv
module gpr_decode #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  localparam int CODE_W   = $clog2(NUM_REGS),
  localparam int SPLIT_W  = $clog2(NUM_SPLIT)
) (
  input  logic              byte_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] idx_o,
  output logic              hi_o
);
  always_comb begin
    if (byte_i) begin
      idx_o = CODE_W'(code_i[SPLIT_W-1:0]);
      hi_o  = code_i[SPLIT_W];
    end else begin
      idx_o = code_i;
      hi_o  = 1'b0;
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  localparam int CODE_W  = $clog2(NUM_REGS),
  localparam int HALF    = DATA_W / 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we_i,
  input  logic                               byte_i,
  input  logic [CODE_W-1:0]                  idx_i,
  input  logic                               hi_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [HALF-1:0] hi_src;

  // a byte write always sources its byte from the low lane of the write data
  assign hi_src = byte_i ? wdata_i[HALF-1:0] : wdata_i[DATA_W-1:HALF];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic sel, lo_en, hi_en;
    assign sel   = we_i && (idx_i == CODE_W'(r));
    assign lo_en = sel && (!byte_i || !hi_i);
    assign hi_en = sel && (!byte_i ||  hi_i);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[r] <= '0;
      end else begin
        if (lo_en) regs_q[r][HALF-1:0]      <= wdata_i[HALF-1:0];
        if (hi_en) regs_q[r][DATA_W-1:HALF] <= hi_src;
      end
    end
  end

  assign regs_o = regs_q;

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(regs_q)); // R7
  AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (we_i && byte_i && !hi_i) |=> regs_q[$past(idx_i)][DATA_W-1:HALF] == $past(regs_q[idx_i][DATA_W-1:HALF])); // R4
  AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (we_i && byte_i && hi_i) |=> regs_q[$past(idx_i)][HALF-1:0] == $past(regs_q[idx_i][HALF-1:0])); // R8
  AST_HIGH_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we_i && byte_i && hi_i) |=> regs_q[$past(idx_i)][DATA_W-1:HALF] == $past(wdata_i[HALF-1:0])); // R8
  AST_WORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we_i && !byte_i) |=> regs_q[$past(idx_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/gpr_rdport.sv
module gpr_rdport #(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  localparam int CODE_W   = $clog2(NUM_REGS),
  localparam int HALF     = DATA_W / 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            byte_i,
  input  logic [CODE_W-1:0]               code_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               data_o
);
  logic [CODE_W-1:0] idx;
  logic              hi;
  logic [DATA_W-1:0] word, sel_d;

  gpr_decode #(.NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)) u_dec (
    .byte_i(byte_i), .code_i(code_i), .idx_o(idx), .hi_o(hi)
  );

  assign word = regs_i[idx];

  always_comb begin
    if (!byte_i)  sel_d = word;
    else if (hi)  sel_d = {{HALF{1'b0}}, word[DATA_W-1:HALF]};
    else          sel_d = {{HALF{1'b0}}, word[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= sel_d;
  end

  AST_BYTE_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    byte_i |=> data_o[DATA_W-1:HALF] == '0); // R3
  AST_READ_IS_OLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    !byte_i |=> data_o == $past(regs_i[code_i])); // R5
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 8,
  parameter int NUM_SPLIT = 4,
  localparam int CODE_W   = $clog2(NUM_REGS),
  localparam int NUM_RD   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd0_byte,
  input  logic [CODE_W-1:0] rd0_code,
  output logic [DATA_W-1:0] rd0_data,
  input  logic              rd1_byte,
  input  logic [CODE_W-1:0] rd1_code,
  output logic [DATA_W-1:0] rd1_data
);
  logic [CODE_W-1:0]               w_idx;
  logic                            w_hi;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0]               rd_byte;
  logic [NUM_RD-1:0][CODE_W-1:0]   rd_code;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  gpr_decode #(.NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)) u_wdec (
    .byte_i(wr_byte), .code_i(wr_code), .idx_o(w_idx), .hi_o(w_hi)
  );

  gpr_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst), .we_i(wr_en), .byte_i(wr_byte),
    .idx_i(w_idx), .hi_i(w_hi), .wdata_i(wr_data), .regs_o(regs)
  );

  assign rd_byte = {rd1_byte, rd0_byte};
  assign rd_code = {rd1_code, rd0_code};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_rdport #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)) u_rd (
      .clk(clk), .rst(rst), .byte_i(rd_byte[p]), .code_i(rd_code[p]),
      .regs_i(regs), .data_o(rd_data[p])
    );
  end

  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd0_data == '0 && rd1_data == '0)); // R1
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd0_byte == rd1_byte && rd0_code == rd1_code) |=> rd0_data == rd1_data); // R6
endmodule

// File: tb/gpr_file_test.sv
module gpr_file_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_byte = 1'b0;
  logic [2:0] wr_code = '0;
  logic [15:0] wr_data = '0;
  logic rd0_byte = 1'b0, rd1_byte = 1'b0;
  logic [2:0] rd0_code = '0, rd1_code = '0;
  logic [15:0] rd0_data, rd1_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] e0;
    logic [15:0] e1;
    string tag;
  } item_t;
  item_t sb[$];
  logic [15:0] model [8];

  always #5 clk = ~clk;

  gpr_file uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .wr_code(wr_code),
    .wr_data(wr_data), .rd0_byte(rd0_byte), .rd0_code(rd0_code), .rd0_data(rd0_data),
    .rd1_byte(rd1_byte), .rd1_code(rd1_code), .rd1_data(rd1_data)
  );

  function automatic logic [15:0] mread(input logic b, input logic [2:0] c);
    logic [15:0] w;
    if (!b) return model[c];
    w = model[c[1:0]];
    return c[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed before the model updates
  task automatic cyc(input logic we, input logic wb, input logic [2:0] wc, input logic [15:0] wd,
                     input logic b0, input logic [2:0] c0, input logic b1, input logic [2:0] c1,
                     input string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_byte = wb; wr_code = wc; wr_data = wd;
    rd0_byte = b0; rd0_code = c0; rd1_byte = b1; rd1_code = c1;
    it.e0 = mread(b0, c0);
    it.e1 = mread(b1, c1);
    it.tag = tag;
    sb.push_back(it);
    if (we) begin
      if (!wb) model[wc] = wd;
      else if (wc[2]) model[wc[1:0]][15:8] = wd[7:0];
      else model[wc[1:0]][7:0] = wd[7:0];
    end
    @(posedge clk);
  endtask

  // monitor: compares the registered read data one edge after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " port0"}, rd0_data, it.e0);
        check({it.tag, " port1"}, rd1_data, it.e1);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk); #1;
    check("R1 reset port0", rd0_data, 16'h0000);
    check("R1 reset port1", rd1_data, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    do_reset();
    // R1: every register reads zero after reset
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 16'h0, 0, 3'(c), 0, 3'(7 - c), "R1 cleared");
    // R2: word writes to each code, read back in order A,C,D,B,SP,BP,SI,DI
    for (int c = 0; c < 8; c++) cyc(1, 0, 3'(c), 16'h1111 * 16'(c + 1) ^ 16'h8421, 0, 0, 0, 0, "R2 write");
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 16'h0, 0, 3'(c), 0, 3'(c), "R2 word read R6");
    // R3: byte reads of all eight byte codes with busy neighbouring halves
    for (int c = 0; c < 4; c++) cyc(1, 0, 3'(c), 16'hFF00 | 16'(c + 1), 0, 0, 0, 0, "R3 setup");
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 16'h0, 1, 3'(c), 1, 3'(c), "R3 byte read");
    // R4: low byte writes keep the high half
    for (int c = 0; c < 4; c++) cyc(1, 1, 3'(c), 16'hBE00 | 16'(8'h5A + c), 0, 3'(c), 1, 3'(c), "R4 low write");
    for (int c = 0; c < 4; c++) cyc(0, 0, 0, 16'h0, 0, 3'(c), 1, 3'(c), "R4 merged");
    // R8: high byte writes keep the low half, ignore wr_data[15:8]
    for (int c = 4; c < 8; c++) cyc(1, 1, 3'(c), 16'hEE00 | 16'(8'hC0 + c), 0, 3'(c - 4), 1, 3'(c), "R8 high write");
    for (int c = 0; c < 4; c++) cyc(0, 0, 0, 16'h0, 0, 3'(c), 1, 3'(c + 4), "R8 merged");
    // R7: write enable low with busy write inputs
    for (int c = 0; c < 8; c++) cyc(0, c[0], 3'(c), 16'hDEAD, 0, 3'(c), 0, 3'(c), "R7 idle");
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 16'h0, 0, 3'(c), 1, 3'(c), "R7 unchanged");
    // R5: same-edge write and read of one register returns the old value
    cyc(1, 0, 3'd5, 16'h1234, 0, 3'd5, 0, 3'd5, "R5 collide word");
    cyc(1, 1, 3'd6, 16'h00AB, 1, 3'd6, 0, 3'd2, "R5 collide byte");
    cyc(0, 0, 0, 16'h0, 0, 3'd5, 0, 3'd2, "R5 after");
    // mixed traffic
    for (int n = 0; n < 300; n++)
      cyc(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom),
          1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom), "R2 R3 R4 R6 R8 mixed");
    cyc(0, 0, 0, 16'h0, 0, 0, 0, 0, "R6 drain");
    repeat (3) @(posedge clk);
    do_reset();
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 16'h0, 0, 3'(c), 1, 3'(c), "R1 cleared again");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule